// File: doc/BRIEF.md
# PLL Unlock Detector with Stretched Indication

This block watches the phase-error pulse of a PLL phase comparator and decides whether the loop is out of lock. A two-bit mode input picks the behaviour. Detection can be off. The raw error pulse can be passed straight through. The width of every error pulse can be measured against a narrow or a wide threshold.

In the two threshold modes, any pulse longer than the threshold counts as a violation. A violation starts an unlock window that is timed by a free-running coarse tick and lasts between one and two tick periods (1 to 2 ms at the default settings). The block drives three results: an active-low status level for a pin, a lock bit for serial readback, and a detection output with its own enable.

Top module: `pll_unlock_detect`

## Requirements
- R1: While `rst_n` is low and `mode` is 00, `lock_bit` and `unlock_n` are 1 and `det_oe` and `det_out` are 0.
- R2: With `mode` = 00, detection is stopped. `det_oe` and `det_out` are 0 and `lock_bit` and `unlock_n` stay 1, whatever `perr` does.
- R3: With `mode` = 01, `det_oe` is 1, `det_out` equals `perr` in the same cycle, and `lock_bit` and `unlock_n` equal the inverse of `perr`.
- R4: With `mode` = 10, a `perr` pulse that stays high for more than NARROW_CYC consecutive cycles (default 5) is a violation. A pulse of NARROW_CYC cycles or fewer is not.
- R5: With `mode` = 11, the same rule applies with WIDE_CYC (default 10) in place of NARROW_CYC.
- R6: In modes 10 and 11, the unlock indication starts in the cycle after the violating cycle. It lasts from TICK_CYC+1 to 2*TICK_CYC cycles after the last violation, because it ends on the second tick that follows. A tick is the last cycle of each TICK_CYC-cycle period counted from the release of reset.
- R7: The unlock indication drives `lock_bit` = 0 and `unlock_n` = 0. With no unlock, both read 1. In modes 10 and 11, `det_oe` is 1 and `det_out` is 1 exactly when unlocked.
- R8: A change of `mode` clears the pending unlock window and the width count at the next clock edge. From the next cycle on, a threshold mode reads locked unless it sees a new violation.
- R9: The width count restarts from zero after every low cycle of `perr`, so pulses separated by a single low cycle do not add up. During a long pulse the count saturates rather than wraps, so the pulse keeps the loop unlocked for as long as it lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perr | input | 1 | Phase-error pulse from the phase comparator |
| mode | input | 2 | 00 off, 01 pass-through, 10 narrow threshold, 11 wide threshold |
| unlock_n | output | 1 | Status pin level: low while unlocked |
| lock_bit | output | 1 | Lock bit for serial readback: 1 while locked |
| det_out | output | 1 | Detection output value |
| det_oe | output | 1 | Detection output enable: 0 means released |

## Verification
Pulses exactly at each threshold and one cycle longer separate the narrow and wide modes from each other and from an off-by-one comparison. Two short pulses split by a single low cycle show that the width count restarts, and a pulse hundreds of cycles long shows that the count saturates instead of wrapping back below the threshold. One isolated violation is timed against the tick phase to bound the window length. A mode switch in the middle of a window must end it one cycle later. Long random mixes of pulse lengths, gaps and mode changes are compared every cycle against a bench model, which catches errors in tick phase and priority that the directed cases miss.

// File: rtl/pll_unlock_detect.sv
module pll_unlock_detect #(
  parameter int NARROW_CYC    = 5,
  parameter int WIDE_CYC      = 10,
  parameter int TICK_CYC      = 9000,
  parameter int STRETCH_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       perr,
  input  logic [1:0] mode,
  output logic       unlock_n,
  output logic       lock_bit,
  output logic       det_out,
  output logic       det_oe
);
  localparam int THR_MAX = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
  localparam int WW = $clog2(THR_MAX + 2);
  localparam int TW = $clog2(TICK_CYC);
  localparam int SW = $clog2(STRETCH_TICKS + 1);

  logic [WW-1:0] wcnt;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] scnt;
  logic [1:0]    mode_q;

  wire           tick     = (tcnt == TW'(TICK_CYC - 1));
  wire [WW-1:0]  thr      = mode[0] ? WW'(WIDE_CYC) : WW'(NARROW_CYC);
  wire           mode_chg = (mode != mode_q);
  wire           viol     = mode[1] && perr && (wcnt >= thr);
  wire           unlock   = (mode == 2'b01) ? perr : (mode[1] && (scnt != '0));

  always_ff @(posedge clk) mode_q <= mode;

  always_ff @(posedge clk) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg || !perr) wcnt <= '0;
    else if (wcnt != '1)             wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg)       scnt <= '0;
    else if (viol)                scnt <= SW'(STRETCH_TICKS);
    else if (tick && scnt != '0)  scnt <= scnt - 1'b1;
  end

  assign unlock_n = ~unlock;
  assign lock_bit = ~unlock;
  assign det_oe   = (mode != 2'b00);
  assign det_out  = det_oe & unlock;
endmodule

module pll_unlock_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       perr,
  input logic [1:0] mode,
  input logic       unlock_n,
  input logic       lock_bit,
  input logic       det_out,
  input logic       det_oe
);
  // R2
  off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!det_oe && !det_out && lock_bit));
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (det_out == perr && lock_bit == !perr));
  // R7
  pin_bit_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit == unlock_n);
  // R7
  det_follows_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (det_oe && det_out == !lock_bit));
  // R8
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (!mode[1] || lock_bit));
endmodule

bind pll_unlock_detect pll_unlock_detect_chk u_chk (.*);

// File: tb/tb_pll_unlock_detect.sv
module tb_pll_unlock_detect;
  localparam int NC = 5, WC = 10, TC = 20;

  logic clk = 0, rst_n = 0, perr = 0;
  logic [1:0] mode = 2'b00;
  logic unlock_n, lock_bit, det_out, det_oe;
  int checks = 0, errors = 0;
  int m_w = 0, m_s = 0, m_t = 0;
  logic [1:0] m_mq = 2'b00;

  always #4 clk = ~clk;

  pll_unlock_detect #(.NARROW_CYC(NC), .WIDE_CYC(WC), .TICK_CYC(TC)) dut (
    .clk(clk), .rst_n(rst_n), .perr(perr), .mode(mode),
    .unlock_n(unlock_n), .lock_bit(lock_bit), .det_out(det_out), .det_oe(det_oe));

  always @(posedge clk) begin
    bit tk, v, chg;
    tk  = (m_t == TC - 1);
    chg = (mode != m_mq);
    v   = mode[1] && perr && (m_w >= (mode[0] ? WC : NC));
    m_mq <= mode;
    if (!rst_n) begin m_w <= 0; m_s <= 0; m_t <= 0; end
    else begin
      m_t <= tk ? 0 : m_t + 1;
      if (chg || !perr) m_w <= 0; else if (m_w < 1000) m_w <= m_w + 1;
      if (chg) m_s <= 0; else if (v) m_s <= 2; else if (tk && m_s != 0) m_s <= m_s - 1;
    end
  end

  function automatic bit exp_unlock();
    if (mode == 2'b01) return perr;
    return mode[1] && (m_s != 0);
  endfunction

  task automatic chk(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(logic p, logic [1:0] m);
    string tag;
    bit u;
    @(negedge clk);
    perr = p; mode = m;
    #2;
    tag = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R7";
    u = (m == 2'b00) ? 1'b0 : exp_unlock();
    chk(tag, lock_bit, !u, "lock_bit");
    chk(tag, unlock_n, !u, "unlock_n");
    chk(tag, det_oe, m != 2'b00, "det_oe");
    chk(tag, det_out, (m != 2'b00) && u, "det_out");
  endtask

  task automatic pulse(int len, logic [1:0] m);
    for (int i = 0; i < len; i++) step(1, m);
    step(0, m);
  endtask

  task automatic idle(int n, logic [1:0] m);
    for (int i = 0; i < n; i++) step(0, m);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", lock_bit, 1, "lock_bit in reset");
    chk("R1", unlock_n, 1, "unlock_n in reset");
    chk("R1", det_oe, 0, "det_oe in reset");
    chk("R1", det_out, 0, "det_out in reset");
    rst_n = 1;

    // R2 off mode ignores a long pulse
    pulse(30, 2'b00);
    chk("R2", lock_bit, 1, "lock after pulse in off mode");

    // R3 pass-through
    pulse(3, 2'b01);
    step(1, 2'b01); chk("R3", det_out, 1, "det_out high");
    step(0, 2'b01); chk("R3", det_out, 0, "det_out low");

    // R4 narrow threshold
    idle(3 * TC, 2'b10);
    pulse(NC, 2'b10);
    chk("R4", lock_bit, 1, "pulse at narrow limit");
    pulse(NC + 1, 2'b10);
    chk("R4", lock_bit, 0, "pulse above narrow limit");

    // R6 window length
    n = 1;
    while (!lock_bit && n < 4 * TC) begin step(0, 2'b10); if (!lock_bit) n++; end
    checks++;
    if (n < TC + 1 || n > 2 * TC) begin
      errors++;
      $display("FAIL R6 window cycles: got %0d expected %0d..%0d", n, TC + 1, 2 * TC);
    end

    // R5 wide threshold
    idle(3 * TC, 2'b11);
    pulse(WC, 2'b11);
    chk("R5", lock_bit, 1, "pulse at wide limit");
    pulse(WC + 1, 2'b11);
    chk("R5", lock_bit, 0, "pulse above wide limit");

    // R8 mode change clears window
    step(0, 2'b10);
    chk("R8", lock_bit, 0, "change cycle still unlocked");
    step(0, 2'b10);
    chk("R8", lock_bit, 1, "cleared after change");

    // R9 restart on low cycle, then saturation
    idle(3 * TC, 2'b10);
    step(1, 2'b10); step(1, 2'b10); step(1, 2'b10); step(1, 2'b10);
    step(0, 2'b10);
    step(1, 2'b10); step(1, 2'b10); step(1, 2'b10); step(1, 2'b10);
    step(0, 2'b10);
    chk("R9", lock_bit, 1, "split pulses do not add");
    for (int i = 0; i < 300; i++) step(1, 2'b11);
    chk("R9", lock_bit, 0, "long pulse still unlocked");
    idle(3 * TC, 2'b11);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0] m;
      m = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : mode;
      pulse($urandom_range(1, 14), m);
      idle($urandom_range(0, 2 * TC), m);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule